// File: doc/BRIEF.md
# Serial DAC Output Formatter

The formatter takes 24-bit signed samples, already at the oversampled rate, and sends each one out MSB first on a single data line. It drives its own bit clock and word clock for the converter. Four run-time fields set the behaviour. The oversampling rate sets the bit-clock period. The word length sets how many of the sample's top bits are sent. The numeric format picks two's complement or complementary offset binary. The word-clock polarity picks which edge marks the start of a word.

Each word occupies exactly 24 bit slots, whatever length is selected. The bit clock is low in the first half of a slot and high in the second half, so a converter latches data on the rising edge. A one-deep holding register takes samples on `in_valid && in_ready`. Its content goes into the next word, and an empty holder produces a zero sample. The configuration fields are sampled only when one word ends and the next begins.

Top module: `dac_serial_formatter`

## Requirements
- R1: While reset is asserted and on release, `ser_data` and `ser_bck` are 0, `in_ready` is 0, and `ser_wck` is 1 (the idle level for polarity 0).
- R2: `cfg_wlen` = 2'b00, 2'b01, 2'b10, 2'b11 selects 16, 18, 20 or 24 bits. The word keeps the top N bits of the sample with no rounding and sends them MSB first in slots 0..N-1. Slots N..23 carry 0.
- R3: With `cfg_cob` = 1, every bit of the truncated word except its MSB is inverted. With 0, the word is sent as two's complement.
- R4: `ser_wck` equals the latched polarity during slots 0..11 and its inverse during slots 12..23. When idle it holds the inverse of `cfg_wck_pol`. With polarity 0 a falling edge starts each word, and with polarity 1 a rising edge does.
- R5: `cfg_osr` = 2'b11, 2'b10, 2'b01 (8x, 4x, 2x) gives a half bit-clock period of 1, 2 or 4 times `BASE_HALF` clock cycles. `ser_bck` is low in the first half of each slot and high in the second.
- R6: Changes to `cfg_osr`, `cfg_wlen`, `cfg_cob` and `cfg_wck_pol` take effect only at the boundary after the current word's last slot. When idle, every cycle is a boundary.
- R7: With `cfg_osr` = 2'b00 at a boundary, the block goes idle. In that state `ser_data` and `ser_bck` are 0 and `in_ready` is 0, until a boundary sees a non-zero code. The first word then starts on the next cycle.
- R8: `in_ready` is high while running with the holder empty. An accepted sample is sent in the next word. A word that starts with the holder empty carries a formatted zero sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_sample | input | 24 | Signed sample |
| in_ready | output | 1 | Holder can take a sample |
| cfg_osr | input | 2 | Oversampling code |
| cfg_wlen | input | 2 | Word length code |
| cfg_cob | input | 1 | 1 selects complementary offset binary |
| cfg_wck_pol | input | 1 | Word-start edge of the word clock |
| ser_data | output | 1 | Serial data |
| ser_bck | output | 1 | Bit clock |
| ser_wck | output | 1 | Word clock |

## Verification
The assertions assume that configuration inputs may change on any cycle. They also assume that `in_sample` is meaningful only when `in_valid` is high. Nothing is assumed about how the producer behaves while `in_ready` is low. The bench changes configuration at deliberately misaligned cycles and sometimes while idle. It also withholds `in_valid` for whole words, so the boundary latching, the underrun path and the entry into and exit from idle all happen inside the checked traffic.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int SAMPLE_W  = 24;
  localparam int SLOT_W    = $clog2(SAMPLE_W);
  localparam int HALF_SLOT = SAMPLE_W / 2;

  typedef enum logic [1:0] {
    OSR_OFF = 2'b00,
    OSR_X2  = 2'b01,
    OSR_X4  = 2'b10,
    OSR_X8  = 2'b11
  } osr_e;

  // number of bits kept for a word-length code
  function automatic logic [SLOT_W:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'b00:   return (SLOT_W+1)'(16);
      2'b01:   return (SLOT_W+1)'(18);
      2'b10:   return (SLOT_W+1)'(20);
      default: return (SLOT_W+1)'(24);
    endcase
  endfunction

  // log2 of the half-period multiplier for an oversampling code
  function automatic logic [1:0] osr_shift(input logic [1:0] code);
    case (code)
      OSR_X2:  return 2'd2;
      OSR_X4:  return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // truncate to the selected length, then optionally flip all but the MSB
  function automatic logic [SAMPLE_W-1:0] fmt_word(input logic [SAMPLE_W-1:0] s,
                                                   input logic [1:0] wl,
                                                   input logic cob);
    logic [SAMPLE_W-1:0] keep;
    logic [SAMPLE_W-1:0] trunc;
    int drop;
    drop = SAMPLE_W - int'(wlen_bits(wl));
    for (int i = 0; i < SAMPLE_W; i++) keep[i] = (i >= drop);
    trunc = s & keep;
    if (cob) trunc = trunc ^ (keep & {1'b0, {(SAMPLE_W-1){1'b1}}});
    return trunc;
  endfunction
endpackage

// File: rtl/dsf_bit_timer.sv
module dsf_bit_timer
  import dsf_pkg::*;
#(
  parameter int BASE_HALF = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [1:0]        osr_act,
  output logic [SLOT_W-1:0] slot,
  output logic              bck_hi,
  output logic              word_end
);
  localparam int PH_W = (4 * BASE_HALF > 2) ? $clog2(4 * BASE_HALF) : 1;

  logic [PH_W-1:0]   phase_q;
  logic              half_q;
  logic [SLOT_W-1:0] slot_q;
  logic [PH_W-1:0]   phase_top;
  logic              phase_last;

  assign phase_top  = PH_W'((BASE_HALF << osr_shift(osr_act)) - 1);
  assign phase_last = (phase_q == phase_top);
  assign word_end   = run && phase_last && half_q && (slot_q == SLOT_W'(SAMPLE_W - 1));
  assign slot       = slot_q;
  assign bck_hi     = half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      half_q  <= 1'b0;
      slot_q  <= '0;
    end else if (!run) begin
      phase_q <= '0;
      half_q  <= 1'b0;
      slot_q  <= '0;
    end else if (phase_last) begin
      phase_q <= '0;
      half_q  <= ~half_q;
      if (half_q) slot_q <= word_end ? '0 : slot_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // R5: the half-period count never runs past the selected length
  a_r5_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (phase_q <= phase_top));
endmodule

// File: rtl/dsf_sample_hold.sv
module dsf_sample_hold
  import dsf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept_en,
  input  logic                take,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                ready,
  output logic                pend_full,
  output logic [SAMPLE_W-1:0] pend_data
);
  logic capture;

  assign ready   = accept_en && !pend_full;
  assign capture = ready && in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_full <= 1'b0;
      pend_data <= '0;
    end else begin
      if (capture) begin
        pend_full <= 1'b1;
        pend_data <= in_data;
      end else if (take) begin
        pend_full <= 1'b0;
      end
    end
  end

  // R8: a held sample is neither lost nor overwritten before a word takes it
  a_r8_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_full && !take) |=> (pend_full && $stable(pend_data)));
endmodule

// File: rtl/dsf_word_shifter.sv
module dsf_word_shifter
  import dsf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] load_word,
  input  logic                run,
  input  logic [SLOT_W-1:0]   slot,
  input  logic                bck_hi,
  input  logic                pol,
  input  logic [1:0]          wlen_act,
  output logic                sdata,
  output logic                bck,
  output logic                wck
);
  logic [SAMPLE_W-1:0] word_q;
  logic [SLOT_W-1:0]   bit_idx;
  logic                first_half;

  assign bit_idx    = SLOT_W'(SAMPLE_W - 1) - slot;
  assign first_half = (slot < SLOT_W'(HALF_SLOT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= load_word;
  end

  always_comb begin
    sdata = run && word_q[bit_idx];
    bck   = run && bck_hi;
    wck   = run ? (first_half ? pol : ~pol) : ~pol;
  end

  // R2: slots past the selected length stay at zero
  a_r2_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ({1'b0, slot} >= wlen_bits(wlen_act))) |-> !sdata);
endmodule

// File: rtl/dac_serial_formatter.sv
module dac_serial_formatter
  import dsf_pkg::*;
#(
  parameter int BASE_HALF = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                in_ready,
  input  logic [1:0]          cfg_osr,
  input  logic [1:0]          cfg_wlen,
  input  logic                cfg_cob,
  input  logic                cfg_wck_pol,
  output logic                ser_data,
  output logic                ser_bck,
  output logic                ser_wck
);
  logic                running;
  logic [1:0]          act_osr;
  logic [1:0]          act_wlen;
  logic                act_pol;
  logic [SLOT_W-1:0]   slot;
  logic                bck_hi;
  logic                word_end;
  logic                boundary_evt;
  logic                load_evt;
  logic                pend_full;
  logic [SAMPLE_W-1:0] pend_data;
  logic [SAMPLE_W-1:0] next_word;

  assign boundary_evt = running ? word_end : 1'b1;
  assign load_evt     = boundary_evt && (cfg_osr != OSR_OFF);
  assign next_word    = fmt_word(pend_full ? pend_data : '0, cfg_wlen, cfg_cob);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      act_osr  <= OSR_OFF;
      act_wlen <= 2'b00;
      act_pol  <= 1'b0;
    end else if (boundary_evt) begin
      running  <= (cfg_osr != OSR_OFF);
      act_osr  <= cfg_osr;
      act_wlen <= cfg_wlen;
      act_pol  <= cfg_wck_pol;
    end
  end

  dsf_bit_timer #(.BASE_HALF(BASE_HALF)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (running),
    .osr_act  (act_osr),
    .slot     (slot),
    .bck_hi   (bck_hi),
    .word_end (word_end)
  );

  dsf_sample_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_en (running),
    .take      (load_evt),
    .in_valid  (in_valid),
    .in_data   (in_sample),
    .ready     (in_ready),
    .pend_full (pend_full),
    .pend_data (pend_data)
  );

  dsf_word_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_evt),
    .load_word (next_word),
    .run       (running),
    .slot      (slot),
    .bck_hi    (bck_hi),
    .pol       (act_pol),
    .wlen_act  (act_wlen),
    .sdata     (ser_data),
    .bck       (ser_bck),
    .wck       (ser_wck)
  );

  // R7: idle keeps data, bit clock and ready low
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!ser_data && !ser_bck && !in_ready));

  // R4: a word that follows a boundary opens at the requested level
  a_r4_word_start_level: assert property (@(posedge clk) disable iff (!rst_n)
    (running && word_end && (cfg_osr != OSR_OFF)) |=> (ser_wck == $past(cfg_wck_pol)));

  // R6: latched settings hold for the whole of a running word
  a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !word_end) |=> $stable({act_osr, act_wlen, act_pol}));
endmodule

// File: tb/dac_serial_formatter_tb.sv
module dac_serial_formatter_tb;
  localparam int BASE = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_sample = 24'h000000;
  logic        in_ready;
  logic [1:0]  cfg_osr = 2'b11;
  logic [1:0]  cfg_wlen = 2'b11;
  logic        cfg_cob = 1'b0;
  logic        cfg_wck_pol = 1'b0;
  logic        ser_data, ser_bck, ser_wck;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string sect = "R1";

  always #2 clk = ~clk;

  dac_serial_formatter #(.BASE_HALF(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_ready(in_ready), .cfg_osr(cfg_osr), .cfg_wlen(cfg_wlen),
    .cfg_cob(cfg_cob), .cfg_wck_pol(cfg_wck_pol),
    .ser_data(ser_data), .ser_bck(ser_bck), .ser_wck(ser_wck)
  );

  // behavioural model state
  bit          m_run = 0;
  int          m_t = 0;
  int          m_hc = 1;
  logic [23:0] m_word = '0;
  logic [23:0] m_pend[$];
  bit          m_pol = 0;
  bit          took = 0;

  function automatic logic [23:0] ref_fmt(logic [23:0] s, logic [1:0] wl, bit cob);
    int n;
    int v;
    n = (wl == 2'b00) ? 16 : (wl == 2'b01) ? 18 : (wl == 2'b10) ? 20 : 24;
    v = int'(s) >> (24 - n);
    if (cob) v = v ^ ((1 << (n - 1)) - 1);
    return 24'(v << (24 - n));
  endfunction

  function automatic int ref_hc(logic [1:0] c);
    return (c == 2'b01) ? 4 * BASE : (c == 2'b10) ? 2 * BASE : BASE;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_t = 0; m_pol = 0; m_word = '0; m_pend.delete();
    end else begin
      bit cap;
      bit bnd;
      cap = m_run && (m_pend.size() == 0) && in_valid;
      bnd = !m_run || (m_t + 1 == 48 * m_hc);
      if (!bnd) m_t++;
      else begin
        m_pol = cfg_wck_pol;
        if (cfg_osr == 2'b00) m_run = 0;
        else begin
          m_run = 1; m_t = 0; m_hc = ref_hc(cfg_osr);
          m_word = ref_fmt((m_pend.size() != 0) ? m_pend[0] : 24'h0, cfg_wlen, cfg_cob);
          m_pend.delete();
        end
      end
      if (cap) begin m_pend.push_back(in_sample); took = 1; end
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] at cycle %0d: got %0b expected %0b", tag, sect, cyc, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 data", ser_data, 1'b0);
      chk("R1 bck", ser_bck, 1'b0);
      chk("R1 wck", ser_wck, 1'b1);
      chk("R1 ready", in_ready, 1'b0);
    end else if (!m_run) begin
      chk("R7 data", ser_data, 1'b0);
      chk("R7 bck", ser_bck, 1'b0);
      chk("R4 idle wck", ser_wck, ~m_pol);
      chk("R7 ready", in_ready, 1'b0);
    end else begin
      int slot;
      slot = m_t / (2 * m_hc);
      chk("R2 R3 data", ser_data, m_word[23 - slot]);
      chk("R5 bck", ser_bck, 1'((m_t / m_hc) % 2));
      chk("R4 wck", ser_wck, (slot < 12) ? m_pol : ~m_pol);
      chk("R8 ready", in_ready, m_pend.size() == 0);
    end
    if (took) begin
      in_sample <= {in_sample[22:0], in_sample[23] ^ in_sample[22] ^ in_sample[21] ^ in_sample[16]} ^ 24'h5A3C1;
      took = 0;
    end
  end

  always @(posedge clk) begin
    if (cyc >= 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, cycle %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    in_sample = 24'h9ABCDE;
    in_valid  = 1'b1;
    wait_n(4);
    rst_n = 1'b1;
    sect = "R2 R5"; wait_n(300);
    sect = "R2 R3";
    for (int w = 0; w < 3; w++) begin
      for (int c = 0; c < 2; c++) begin
        cfg_wlen = 2'(w); cfg_cob = c[0];
        wait_n(150);
      end
    end
    cfg_wlen = 2'b11; cfg_cob = 1'b1; wait_n(150);
    sect = "R4 R5";
    cfg_wck_pol = 1'b1; cfg_osr = 2'b10; wait_n(260);
    cfg_osr = 2'b01; wait_n(460);
    sect = "R6";
    for (int k = 0; k < 6; k++) begin
      wait_n(37);
      cfg_wlen = 2'(k); cfg_cob = ~cfg_cob; cfg_wck_pol = ~cfg_wck_pol;
      cfg_osr = (k % 2 == 0) ? 2'b11 : 2'b10;
    end
    wait_n(200);
    sect = "R7";
    cfg_osr = 2'b00; wait_n(150);
    cfg_wck_pol = ~cfg_wck_pol; wait_n(20);
    cfg_osr = 2'b11; wait_n(200);
    sect = "R8";
    in_valid = 1'b0; wait_n(200);
    cfg_cob = 1'b1; wait_n(100);
    in_valid = 1'b1; wait_n(150);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule